// File: doc/BRIEF.md
# Dual-Source Instruction Clock and Halt Controller

This block produces the instruction-cycle enable for a small processor core. The core can be clocked from one of two sources: a primary clock, or a secondary oscillator that is allowed only in dual-source mode. Both sources reach the block as level inputs sampled in the single system-clock domain. Each source passes through its own synchronizer, and its rising edges are counted. Every fourth rising edge of the selected source produces one enable pulse. A separate time-base tick is produced in the same way from the primary source alone, whichever source drives the core. The selected source only changes at an instruction-cycle boundary.

The block also controls a low-power halt state. A halt request is held pending until the synchronized primary level is high. The halt status output then rises and stays high. While halted, the phase counters are frozen, and no enable or tick is produced. The status pin also serves as the wake input. An external driver that pulls it low (the `cont_low` input) resumes operation from the exact phase where it stopped. Reset also ends a halt, but as a restart from phase zero. A halt request is refused while the core runs from the secondary source.

Top module: `clk_halt_ctrl`

## Requirements
- R1: Exactly one `cyc_en` pulse, one cycle wide, is produced for every 4 rising edges of the selected source.
- R2: When `dual_n` is 1, only the primary source drives the core. Secondary edges produce no `cyc_en`, and `sel_sec` has no effect.
- R3: When `dual_n` is 0, `sel_sec`=1 selects the secondary source and `sel_sec`=0 selects the primary source.
- R4: `tb_tick` pulses once for every 4 primary rising edges. This holds even while the core runs from the secondary source.
- R5: A change of source takes effect only after a `cyc_en` pulse. Edges of the newly selected source do not count before then.
- R6: A halt request takes effect only when the synchronized primary level is high. `hstat_out` then rises and stays high until a continue or a reset.
- R7: While halted, no `cyc_en` and no `tb_tick` are produced, and both phase counters keep their values.
- R8: If `cont_low` is 1 while halted, the halt ends and counting resumes at the retained phase. `hstat_out` then stays low.
- R9: Reset ends a halt, returns both phase counters to zero and selects the primary source.
- R10: A halt request made while the core runs from the secondary source is ignored.
- R11: After reset, `cyc_en`, `tb_tick` and `hstat_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (restart) |
| pri_lvl | input | 1 | Primary source level |
| sec_lvl | input | 1 | Secondary oscillator level |
| dual_n | input | 1 | Dual-source strap, 0 enables dual-source mode |
| sel_sec | input | 1 | Source-select latch bit, 1 selects the secondary source |
| halt_req | input | 1 | Halt request pulse |
| cont_low | input | 1 | 1 when an external driver pulls the status pin low (continue) |
| cyc_en | output | 1 | Instruction-cycle enable pulse |
| tb_tick | output | 1 | Time-base tick derived from the primary source |
| hstat_out | output | 1 | Halt status pin drive, 1 while halted |

## Verification
The core phase counter is internal, but an error in it shows at the ports within one instruction cycle. `cyc_en` then appears after the wrong number of source edges, or is missed at a resume. A wrong source selection shows as enables that follow the wrong input, or as a switch before the cycle boundary. These appear in the enable counts over windows of 2 to 8 source edges. A wrong halt state shows on `hstat_out` within a few system cycles after a halt request or a continue. It also shows as enables or ticks that appear while the status pin is high.

// File: rtl/clk_halt_pkg.sv
package clk_halt_pkg;
  localparam int NUM_SRC = 2;
  localparam int SRC_PRI = 0;
  localparam int SRC_SEC = 1;

  typedef enum logic {
    SEL_PRI = 1'b0,
    SEL_SEC = 1'b1
  } src_sel_e;
endpackage

// File: rtl/lvl_sync.sv
module lvl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic lvl_s
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], lvl};
  end

  assign lvl_s = sh[STAGES-1];
endmodule

// File: rtl/phase_div.sv
module phase_div #(
  parameter int PH_W = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic hold,
  output logic wrap
);
  localparam logic [PH_W-1:0] PH_LAST = '1;

  logic [PH_W-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= '0;
      wrap <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (step && !hold) begin
        ph   <= ph + 1'b1;
        wrap <= (ph == PH_LAST);
      end
    end
  end
endmodule

// File: rtl/halt_ctrl.sv
module halt_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic halt_req,
  input  logic cont_low,
  input  logic pri_hi,
  input  logic on_sec,
  output logic halted
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      halted <= 1'b0;
      pend   <= 1'b0;
    end else if (halted) begin
      if (cont_low) halted <= 1'b0;
    end else if (on_sec) begin
      pend <= 1'b0;
    end else if ((pend || halt_req) && pri_hi) begin
      halted <= 1'b1;
      pend   <= 1'b0;
    end else if (halt_req) begin
      pend <= 1'b1;
    end
  end
endmodule

// File: rtl/clk_halt_ctrl.sv
module clk_halt_ctrl
  import clk_halt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PH_W        = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pri_lvl,
  input  logic sec_lvl,
  input  logic dual_n,
  input  logic sel_sec,
  input  logic halt_req,
  input  logic cont_low,
  output logic cyc_en,
  output logic tb_tick,
  output logic hstat_out
);
  logic [NUM_SRC-1:0] src_lvl;
  logic [NUM_SRC-1:0] src_sync;
  logic [NUM_SRC-1:0] src_dly;
  logic [NUM_SRC-1:0] src_rise;
  src_sel_e           act_src;
  logic               on_sec;
  logic               core_step;
  logic               halted;
  logic               pri_hi;

  assign src_lvl = {sec_lvl, pri_lvl};

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    lvl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst   (rst),
      .lvl   (src_lvl[g]),
      .lvl_s (src_sync[g])
    );

    always_ff @(posedge clk) begin
      if (rst) src_dly[g] <= 1'b0;
      else     src_dly[g] <= src_sync[g];
    end

    assign src_rise[g] = src_sync[g] & ~src_dly[g];
  end

  assign on_sec    = (act_src == SEL_SEC);
  assign core_step = on_sec ? src_rise[SRC_SEC] : src_rise[SRC_PRI];
  assign pri_hi    = src_sync[SRC_PRI];

  // the source changes only after a completed instruction cycle
  always_ff @(posedge clk) begin
    if (rst)         act_src <= SEL_PRI;
    else if (cyc_en) act_src <= (!dual_n && sel_sec) ? SEL_SEC : SEL_PRI;
  end

  phase_div #(.PH_W(PH_W)) u_core_div (
    .clk  (clk),
    .rst  (rst),
    .step (core_step),
    .hold (halted),
    .wrap (cyc_en)
  );

  phase_div #(.PH_W(PH_W)) u_tb_div (
    .clk  (clk),
    .rst  (rst),
    .step (src_rise[SRC_PRI]),
    .hold (halted),
    .wrap (tb_tick)
  );

  halt_ctrl u_halt (
    .clk      (clk),
    .rst      (rst),
    .halt_req (halt_req),
    .cont_low (cont_low),
    .pri_hi   (pri_hi),
    .on_sec   (on_sec),
    .halted   (halted)
  );

  assign hstat_out = halted;
endmodule

// File: rtl/clk_halt_chk.sv
module clk_halt_chk (
  input logic clk,
  input logic rst,
  input logic cont_low,
  input logic cyc_en,
  input logic tb_tick,
  input logic hstat_out,
  input logic on_sec,
  input logic pri_hi
);
  AST_EN_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cyc_en |=> !cyc_en); // R1

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (hstat_out && $past(hstat_out)) |-> (!cyc_en && !tb_tick)); // R7

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (hstat_out && !cont_low) |=> hstat_out); // R6

  AST_HALT_ON_PRI_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(hstat_out) |-> $past(pri_hi)); // R6

  AST_CONT_WAKE: assert property (@(posedge clk) disable iff (rst)
    (hstat_out && cont_low) |=> !hstat_out); // R8

  AST_NO_HALT_ON_SEC: assert property (@(posedge clk) disable iff (rst)
    on_sec |-> !hstat_out); // R10

  AST_SWITCH_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !$stable(on_sec) |-> $past(cyc_en)); // R5
endmodule

bind clk_halt_ctrl clk_halt_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cont_low  (cont_low),
  .cyc_en    (cyc_en),
  .tb_tick   (tb_tick),
  .hstat_out (hstat_out),
  .on_sec    (on_sec),
  .pri_hi    (pri_hi)
);

// File: tb/sim_clk_halt_ctrl.sv
`timescale 1ns/1ps
module sim_clk_halt_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pri_lvl = 1'b0, sec_lvl = 1'b0, dual_n = 1'b1, sel_sec = 1'b1;
  logic halt_req = 1'b0, cont_low = 1'b0;
  logic cyc_en, tb_tick, hstat_out;

  int n_cmp = 0, n_bad = 0, cnt_en = 0, cnt_tb = 0;
  bit done = 1'b0;

  typedef struct { string req; int en; int tb; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  clk_halt_ctrl u0 (
    .clk(clk), .rst(rst), .pri_lvl(pri_lvl), .sec_lvl(sec_lvl),
    .dual_n(dual_n), .sel_sec(sel_sec), .halt_req(halt_req),
    .cont_low(cont_low), .cyc_en(cyc_en), .tb_tick(tb_tick),
    .hstat_out(hstat_out)
  );

  // monitor: counts pulses and compares against scoreboard entries
  always @(negedge clk) begin
    if (!rst) begin
      if (cyc_en)  cnt_en++;
      if (tb_tick) cnt_tb++;
    end
    if (exp_q.size() != 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if (cnt_en != e.en || cnt_tb != e.tb) begin
        n_bad++;
        $display("FAIL %s: en/tb actual %0d/%0d expected %0d/%0d",
                 e.req, cnt_en, cnt_tb, e.en, e.tb);
      end
      cnt_en = 0;
      cnt_tb = 0;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic edges(input bit p, input bit s, input int n);
    for (int i = 0; i < n; i++) begin
      pri_lvl = p; sec_lvl = s; idle(4);
      pri_lvl = 1'b0; sec_lvl = 1'b0; idle(4);
    end
  endtask

  task automatic push(input string req, input int en, input int tb);
    exp_t e;
    idle(4);
    e.req = req; e.en = en; e.tb = tb;
    exp_q.push_back(e);
    idle(2);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse_halt();
    halt_req = 1'b1; idle(1); halt_req = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    idle(20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R11 reset state
    chk("R11 hstat", hstat_out, 1'b0);
    chk("R11 cyc_en", cyc_en, 1'b0);
    chk("R11 tb_tick", tb_tick, 1'b0);
    // R2 single-source strap: secondary ignored even with sel_sec=1
    edges(0, 1, 8); push("R2", 0, 0);
    edges(1, 0, 8); push("R1", 2, 2);
    // R3 dual mode selects secondary after the next boundary
    dual_n = 1'b0;
    edges(1, 0, 4); push("R3", 1, 1);
    edges(0, 1, 8); push("R3", 2, 0);
    edges(1, 0, 8); push("R4", 0, 2);
    // R5 switch back to primary waits for a cycle boundary
    sel_sec = 1'b0;
    edges(0, 1, 2); push("R5", 0, 0);
    edges(1, 0, 4); push("R5", 0, 1);
    edges(0, 1, 2); push("R5", 1, 0);
    edges(0, 1, 4); push("R5", 0, 0);
    edges(1, 0, 4); push("R5", 1, 1);
    // R10 halt refused on secondary
    sel_sec = 1'b1;
    edges(1, 0, 4); push("R3", 1, 1);
    pulse_halt(); idle(6);
    chk("R10 hstat", hstat_out, 1'b0);
    edges(0, 1, 4); push("R10", 1, 0);
    sel_sec = 1'b0;
    edges(0, 1, 4); push("R10", 1, 0);
    // R6/R7/R8 halt with primary low, then primary high, then continue
    edges(1, 0, 2); push("R7", 0, 0);
    pulse_halt(); idle(6);
    chk("R6 waits for primary high", hstat_out, 1'b0);
    pri_lvl = 1'b1; idle(4);
    chk("R6 halted", hstat_out, 1'b1);
    pri_lvl = 1'b0; idle(4);
    edges(1, 0, 4); push("R7", 0, 0);
    chk("R6 stays high", hstat_out, 1'b1);
    cont_low = 1'b1; idle(1); cont_low = 1'b0; idle(3);
    chk("R8 woken", hstat_out, 1'b0);
    edges(1, 0, 1); push("R8", 1, 1);
    idle(10);
    chk("R8 stays low", hstat_out, 1'b0);
    // R9 reset ends halt and restarts phase
    pulse_halt();
    pri_lvl = 1'b1; idle(4); pri_lvl = 1'b0; idle(4);
    chk("R9 halted", hstat_out, 1'b1);
    push("R9", 0, 0);
    rst = 1'b1; idle(3); rst = 1'b0; idle(1);
    chk("R9 reset clears halt", hstat_out, 1'b0);
    edges(1, 0, 4); push("R9", 1, 1);
    idle(4);
    finish_run();
  end
endmodule